// File: doc/BRIEF.md
# Posit Magnitude Range Monitor

This block watches a stream of posit results and keeps the extremes of their magnitude. One register holds the smallest nonzero magnitude seen since the last clear, and the other holds the largest. Two sticky flags report whether any result reached the smallest representable nonzero magnitude (minPos) or the largest (maxPos). Reaching either one means a severe loss of accuracy, so these flags replace the usual underflow and overflow warnings.

Posit bit patterns sort in the same order as two's-complement integers. The block therefore takes the absolute value of each sample with an integer negation and compares the results with plain unsigned comparators. It needs no floating-point compare logic. Each valid sample is handled in a single cycle. Software can issue a clear at any time.

Top module: `posit_range_mon`

## Requirements
- R1: While reset is asserted and after reset, `min_mag` is all ones (the maxPos magnitude), `max_mag` is zero, and both flags are 0.
- R2: The magnitude of a sample is the sample itself when bit NBITS-1 is 0. When that bit is 1, the magnitude is its two's-complement negation. Only the low NBITS-1 bits are kept.
- R3: On the clock edge that takes an accepted sample whose magnitude is below `min_mag`, `min_mag` becomes that magnitude. Otherwise `min_mag` is unchanged.
- R4: On the clock edge that takes an accepted sample whose magnitude is above `max_mag`, `max_mag` becomes that magnitude. Otherwise `max_mag` is unchanged.
- R5: A sample that is all zeros (zero), or that has only bit NBITS-1 set (NaR), changes neither register nor flag.
- R6: A cycle with `clr` high returns the registers and flags to the R1 state on the next edge.
- R7: When `clr` and `smp_valid` are high in the same cycle, the clear wins and the sample has no effect.
- R8: `hit_minpos` sets when an accepted magnitude equals 1. It stays set until a clear.
- R9: `hit_maxpos` sets when an accepted magnitude equals all ones (NBITS-1 bits). It stays set until a clear.
- R10: With `smp_valid` and `clr` both low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears both registers and both flags |
| smp_valid | input | 1 | `smp_word` carries a result to track |
| smp_word | input | NBITS | Posit bit pattern |
| min_mag | output | NBITS-1 | Smallest nonzero magnitude seen |
| max_mag | output | NBITS-1 | Largest magnitude seen |
| hit_minpos | output | 1 | Sticky flag: magnitude minPos reached |
| hit_maxpos | output | 1 | Sticky flag: magnitude maxPos reached |

## Verification
The clear command and a valid sample can arrive in the same cycle. The bench provokes this by driving `clr` together with a minPos sample that would otherwise set a flag and lower the minimum. A correct result shows the cleared state on the next edge, with the flag still low. A following sample on its own then shows that the first sample after a clear replaces both registers.

// File: rtl/posit_range_mon.sv
module posit_range_mon #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_valid,
  input  logic [NBITS-1:0] smp_word,
  output logic [NBITS-2:0] min_mag,
  output logic [NBITS-2:0] max_mag,
  output logic             hit_minpos,
  output logic             hit_maxpos
);
  localparam int MW = NBITS - 1;
  localparam logic [MW-1:0] MAXP = '1;
  localparam logic [MW-1:0] MINP = {{(MW-1){1'b0}}, 1'b1};
  localparam logic [NBITS-1:0] NAR = {1'b1, {MW{1'b0}}};

  logic [NBITS-1:0] neg_w;
  logic [MW-1:0]    mag;
  logic             take;

  assign neg_w = -smp_word;
  assign mag   = smp_word[NBITS-1] ? neg_w[MW-1:0] : smp_word[MW-1:0];
  assign take  = smp_valid && !clr && (smp_word != '0) && (smp_word != NAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_mag    <= MAXP;
      max_mag    <= '0;
      hit_minpos <= 1'b0;
      hit_maxpos <= 1'b0;
    end else if (clr) begin
      min_mag    <= MAXP;
      max_mag    <= '0;
      hit_minpos <= 1'b0;
      hit_maxpos <= 1'b0;
    end else if (take) begin
      if (mag < min_mag) min_mag <= mag;
      if (mag > max_mag) max_mag <= mag;
      if (mag == MINP) hit_minpos <= 1'b1;
      if (mag == MAXP) hit_maxpos <= 1'b1;
    end
  end
endmodule

// File: rtl/posit_range_mon_chk.sv
module posit_range_mon_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             smp_valid,
  input logic [NBITS-2:0] min_mag,
  input logic [NBITS-2:0] max_mag,
  input logic             hit_minpos,
  input logic             hit_maxpos
);
  localparam logic [NBITS-2:0] ONE = {{(NBITS-2){1'b0}}, 1'b1};

  p_min_never_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> min_mag <= $past(min_mag));
  p_max_never_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> max_mag >= $past(max_mag));
  p_clear_state_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (min_mag == '1) && (max_mag == '0) && !hit_minpos && !hit_maxpos);
  p_minflag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_minpos && !clr |=> hit_minpos);
  p_minflag_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_minpos |-> min_mag == ONE);
  p_maxflag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_maxpos && !clr |=> hit_maxpos);
  p_maxflag_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_maxpos |-> max_mag == '1);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !clr |=> $stable(min_mag) && $stable(max_mag)
                           && $stable(hit_minpos) && $stable(hit_maxpos));
endmodule

bind posit_range_mon posit_range_mon_chk #(.NBITS(NBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
  .min_mag(min_mag), .max_mag(max_mag),
  .hit_minpos(hit_minpos), .hit_maxpos(hit_maxpos));

// File: tb/posit_range_mon_tb_top.sv
`timescale 1ns/1ps
module posit_range_mon_tb_top;
  localparam int N = 16;
  typedef struct {
    logic [N-2:0] mn, mx;
    logic fmin, fmax;
    int due;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, clr = 0, smp_valid = 0;
  logic [N-1:0] smp_word = '0;
  logic [N-2:0] min_mag, max_mag;
  logic hit_minpos, hit_maxpos;
  int cyc = 0, nvec = 0, nbad = 0;
  bit done = 0;
  exp_t q[$];
  logic [N-2:0] m_mn = '1, m_mx = '0;
  logic m_fmin = 0, m_fmax = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  posit_range_mon #(.NBITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid), .smp_word(smp_word),
    .min_mag(min_mag), .max_mag(max_mag), .hit_minpos(hit_minpos), .hit_maxpos(hit_maxpos));

  task automatic drive(input logic v, input logic [N-1:0] w, input logic c, input string tag);
    logic [N-1:0] a;
    exp_t e;
    @(negedge clk);
    smp_valid = v; smp_word = w; clr = c;
    a = w[N-1] ? (~w + 1'b1) : w;
    if (c) begin
      m_mn = '1; m_mx = '0; m_fmin = 0; m_fmax = 0;
    end else if (v && w != '0 && w != {1'b1, {(N-1){1'b0}}}) begin
      if (a[N-2:0] < m_mn) m_mn = a[N-2:0];
      if (a[N-2:0] > m_mx) m_mx = a[N-2:0];
      if (a[N-2:0] == 1) m_fmin = 1;
      if (a[N-2:0] == '1) m_fmax = 1;
    end
    e.mn = m_mn; e.mx = m_mx; e.fmin = m_fmin; e.fmax = m_fmax;
    e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      nvec++;
      if (min_mag !== e.mn || max_mag !== e.mx || hit_minpos !== e.fmin || hit_maxpos !== e.fmax) begin
        nbad++;
        $display("FAIL %s: got min=%h max=%h fmin=%b fmax=%b, expected min=%h max=%h fmin=%b fmax=%b",
                 e.tag, min_mag, max_mag, hit_minpos, hit_maxpos, e.mn, e.mx, e.fmin, e.fmax);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (min_mag !== '1 || max_mag !== '0 || hit_minpos || hit_maxpos) begin
      nbad++;
      $display("FAIL R1: got min=%h max=%h flags=%b%b, expected 7fff 0000 00",
               min_mag, max_mag, hit_minpos, hit_maxpos);
    end
    rst_n = 1;
    drive(0, 16'h0000, 0, "R10 idle after reset");
    drive(1, 16'h4000, 0, "R3 R4 first sample sets both");
    drive(1, 16'hC000, 0, "R2 negative of same magnitude");
    drive(1, 16'h0100, 0, "R3 new minimum");
    drive(1, 16'h7000, 0, "R4 new maximum");
    drive(1, 16'hF000, 0, "R2 negative 0x1000 magnitude");
    drive(1, 16'h0000, 0, "R5 zero ignored");
    drive(1, 16'h8000, 0, "R5 NaR ignored");
    drive(0, 16'h0001, 0, "R10 word without valid");
    drive(1, 16'h2000, 0, "R3 R4 in-range no change");
    drive(1, 16'hFFFF, 0, "R8 R2 minPos via negative");
    drive(1, 16'h0300, 0, "R8 flag sticky");
    drive(1, 16'h8001, 0, "R9 R2 maxPos via negative");
    drive(1, 16'h0500, 0, "R9 flag sticky");
    drive(0, 16'h0000, 1, "R6 clear");
    drive(1, 16'h0001, 1, "R7 clear beats minPos sample");
    drive(1, 16'h1234, 0, "R3 R4 first after clear");
    drive(1, 16'h7FFF, 0, "R9 maxPos positive");
    drive(1, 16'h0001, 0, "R8 minPos positive");
    drive(1, 16'h7FFF, 1, "R7 clear beats maxPos sample");
    drive(0, 16'h0000, 0, "R10 idle after clear");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule